// File: doc/BRIEF.md
# Weakest Sub-Carrier List Manager

This block runs alongside channel preprocessing, once per packet. For every data sub-carrier it takes two last-diagonal magnitudes, one from each layer ordering of the triangular factorisation, and the carrier index. The smaller of the two is the carrier's ranking key; a low key means a badly faded tone. A short insertion-sorted register list keeps the NH lowest keys seen so far, with their carrier indices.

When the final sub-carrier of the packet has been taken, the block turns the list into a bitmap of NDC one-bit mode flags. It writes the bitmap in one cycle and pulses `done`. A set flag tells the demodulator to run the full constellation search on that carrier. A clear flag selects the reduced search. The demodulator reads flags by index through a combinational read port. A start-of-packet pulse empties both the list and the bitmap.

The input is a valid/ready stream. `in_ready` stays high at all times: the list absorbs one sample per clock, so the upstream unit (which issues at most one sample every two cycles) is never held back. A sample counts as taken on any rising edge where `in_valid` is high and `pkt_start` is low.

Top module: `weak_tone_selector`

## Requirements
- R1: The ranking key of a sub-carrier is the smaller of `in_key_a` and `in_key_b`, compared as 16-bit unsigned values.
- R2: After a packet, the flagged carriers are the NH taken samples with the lowest keys. A new key replaces the largest list entry only when it is strictly smaller than that entry.
- R3: When keys are equal, the carrier taken earlier ranks lower, so it is kept. A new key equal to the largest entry of a full list is dropped.
- R4: While the list holds fewer than NH entries, every valid sample enters it. If a packet carries fewer than NH carriers, only those carriers are flagged.
- R5: `rd_flag` shows the flag of carrier `rd_idx` combinationally: 1 selects full search and 0 selects reduced search. Indices at or above NDC read as 0.
- R6: `pkt_start` empties the list and clears every flag at the next edge. It wins over a sample presented in the same cycle, and that sample is not taken.
- R7: The flags change only at the edge after the sample marked `in_last` is taken. `done` is high for exactly that one cycle, and the new flags are readable in the same cycle.
- R8: `in_ready` is always 1, and a sample is taken on every cycle with `in_valid` high.
- R9: A sample whose index is NDC or larger is discarded. It takes no list slot.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | Start of packet: clears the list and the flags |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample ready, always 1 |
| in_last | input | 1 | Marks the final sub-carrier of the packet |
| in_idx | input | IW (6) | Sub-carrier index |
| in_key_a | input | KW (16) | Last diagonal magnitude, first layer ordering |
| in_key_b | input | KW (16) | Last diagonal magnitude, second layer ordering |
| done | output | 1 | One-cycle pulse when the flags have been written |
| rd_idx | input | IW (6) | Flag read index |
| rd_flag | output | 1 | Flag of carrier `rd_idx` (1 = full search) |

## Verification
The bench uses a packet that fills the list and then evicts entries. Among the keys near the boundary is a three-way tie. A design that compares with "less or equal", or inserts ties ahead of earlier entries, flags the wrong carrier of the tie.

A packet with six equal keys is sent behind an out-of-range index that carries the smallest key. If the design lets a tie evict an entry, or lets a bad index take a slot, the sixth carrier or no carrier ends up flagged.

A three-carrier packet at indices 0 and 51 checks partial fill and the ends of the flag array. Leftover flags from the previous packet would show up here.

The timing of `done` and of the flag update is checked cycle by cycle. So is a `pkt_start` that collides with a valid sample. An off-by-one commit or a lost clear shows up as a flag or pulse in the wrong cycle.

// File: rtl/wts_pkg.sv
package wts_pkg;
  // collection phase of the list manager
  typedef enum logic {
    PH_COLLECT = 1'b0,
    PH_COMMIT  = 1'b1
  } phase_t;
endpackage

// File: rtl/wts_key_min.sv
module wts_key_min #(
  parameter int KW = 16
) (
  input  logic [KW-1:0] a,
  input  logic [KW-1:0] b,
  output logic [KW-1:0] y
);
  // ranking key: the weaker of the two orderings
  assign y = (a < b) ? a : b;
endmodule

// File: rtl/wts_sort_list.sv
module wts_sort_list #(
  parameter int NH  = 5,
  parameter int KW  = 16,
  parameter int IW  = 6,
  parameter int NDC = 52
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ins_valid,
  input  logic [KW-1:0] ins_key,
  input  logic [IW-1:0] ins_idx,
  output logic [NH-1:0] vld_o,
  output logic [IW-1:0] idx_o [NH]
);
  localparam logic [IW:0] NDC_L = (IW+1)'(NDC);

  logic [NH-1:0] vld_q;
  logic [KW-1:0] key_q [NH];
  logic [IW-1:0] idx_q [NH];
  logic [NH-1:0] take;
  logic          ins_ok;

  // out-of-range indices never enter the list
  assign ins_ok = ins_valid && ({1'b0, ins_idx} < NDC_L);

  // take[i]: the new key belongs at or above slot i. Strict compare puts
  // the newcomer behind equal keys, so the earlier carrier ranks lower.
  for (genvar i = 0; i < NH; i++) begin : g_cmp
    assign take[i] = ins_ok && (!vld_q[i] || (ins_key < key_q[i]));
  end

  for (genvar i = 0; i < NH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[i] <= 1'b0;
          key_q[i] <= '0;
          idx_q[i] <= '0;
        end else if (clr) begin
          vld_q[i] <= 1'b0;
        end else if (take[i]) begin
          vld_q[i] <= 1'b1;
          key_q[i] <= ins_key;
          idx_q[i] <= ins_idx;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q[i] <= 1'b0;
          key_q[i] <= '0;
          idx_q[i] <= '0;
        end else if (clr) begin
          vld_q[i] <= 1'b0;
        end else if (take[i]) begin
          if (take[i-1]) begin
            // shift the entry above down by one place
            vld_q[i] <= vld_q[i-1];
            key_q[i] <= key_q[i-1];
            idx_q[i] <= idx_q[i-1];
          end else begin
            vld_q[i] <= 1'b1;
            key_q[i] <= ins_key;
            idx_q[i] <= ins_idx;
          end
        end
      end

      // R2
      sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q[i] |-> (vld_q[i-1] && (key_q[i-1] <= key_q[i])));
    end
    assign idx_o[i] = idx_q[i];
  end

  assign vld_o = vld_q;

  // R6
  list_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (vld_q == '0));

  // R3
  tie_no_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ins_valid && vld_q[NH-1] && (ins_key >= key_q[NH-1]))
      |=> ($stable(key_q[NH-1]) && $stable(idx_q[NH-1])));

  // R4
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ins_ok && !vld_q[NH-1]) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));
endmodule

// File: rtl/wts_flag_map.sv
module wts_flag_map #(
  parameter int NDC = 52,
  parameter int NH  = 5,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          commit,
  input  logic [NH-1:0] vld,
  input  logic [IW-1:0] idx [NH],
  input  logic [IW-1:0] rd_idx,
  output logic          rd_flag
);
  localparam int SPAN = 1 << IW;

  logic [NDC-1:0]  hit;
  logic [NDC-1:0]  flag_q;
  logic [SPAN-1:0] flag_pad;

  // one comparator row per carrier: is any list entry pointing here
  for (genvar c = 0; c < NDC; c++) begin : g_carrier
    logic [NH-1:0] match;
    for (genvar j = 0; j < NH; j++) begin : g_entry
      assign match[j] = vld[j] && (idx[j] == IW'(c));
    end
    assign hit[c] = |match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (clr) begin
      flag_q <= '0;
    end else if (commit) begin
      flag_q <= hit;
    end
  end

  // zero-extended copy: indices past NDC read as reduced search
  assign flag_pad = SPAN'(flag_q);
  assign rd_flag  = flag_pad[rd_idx];

  // R4
  flag_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flag_q) <= NH);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flag_q == '0));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !commit) |=> $stable(flag_q));
endmodule

// File: rtl/weak_tone_selector.sv
module weak_tone_selector
  import wts_pkg::*;
#(
  parameter int NDC = 52,
  parameter int NH  = 5,
  parameter int KW  = 16,
  parameter int IW  = $clog2(NDC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pkt_start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  input  logic [IW-1:0] in_idx,
  input  logic [KW-1:0] in_key_a,
  input  logic [KW-1:0] in_key_b,
  output logic          done,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_flag
);
  phase_t        phase_q;
  logic          done_q;
  logic          accept;
  logic          commit;
  logic [KW-1:0] key;
  logic [NH-1:0] lst_vld;
  logic [IW-1:0] lst_idx [NH];

  // the list takes one sample per clock, so no back-pressure is needed
  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready && !pkt_start;
  assign commit   = (phase_q == PH_COMMIT) && !pkt_start;

  wts_key_min #(.KW(KW)) u_min (
    .a (in_key_a),
    .b (in_key_b),
    .y (key)
  );

  wts_sort_list #(.NH(NH), .KW(KW), .IW(IW), .NDC(NDC)) u_list (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pkt_start),
    .ins_valid (accept),
    .ins_key   (key),
    .ins_idx   (in_idx),
    .vld_o     (lst_vld),
    .idx_o     (lst_idx)
  );

  wts_flag_map #(.NDC(NDC), .NH(NH), .IW(IW)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (pkt_start),
    .commit  (commit),
    .vld     (lst_vld),
    .idx     (lst_idx),
    .rd_idx  (rd_idx),
    .rd_flag (rd_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_COLLECT;
      done_q  <= 1'b0;
    end else begin
      done_q <= commit;
      if (pkt_start) begin
        phase_q <= PH_COLLECT;
      end else if (accept && in_last) begin
        phase_q <= PH_COMMIT;
      end else begin
        phase_q <= PH_COLLECT;
      end
    end
  end

  assign done = done_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !pkt_start) |=> ##1 (done_q || $past(pkt_start)));

  // R6
  start_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !done_q);
endmodule

// File: tb/weak_tone_selector_bench.sv
module weak_tone_selector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NDC = 52;
  localparam int NH  = 5;
  localparam int KW  = 16;
  localparam int IW  = 6;
  localparam int NV  = 12;

  // row: {idx, key_a, key_b, expected flag}
  localparam logic [38:0] VEC [NV] = '{
    {6'd3,  16'd650,   16'd900,   1'b1},
    {6'd7,  16'd1200,  16'd300,   1'b1},
    {6'd10, 16'd800,   16'd800,   1'b0},
    {6'd15, 16'd100,   16'd2000,  1'b1},
    {6'd20, 16'd700,   16'd650,   1'b0},
    {6'd22, 16'd650,   16'd999,   1'b0},
    {6'd30, 16'd4000,  16'd4000,  1'b0},
    {6'd31, 16'd60000, 16'd200,   1'b1},
    {6'd40, 16'd900,   16'd1000,  1'b0},
    {6'd45, 16'd5000,  16'd450,   1'b1},
    {6'd50, 16'd700,   16'd750,   1'b0},
    {6'd51, 16'd65535, 16'd65535, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pkt_start = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          in_last = 1'b0;
  logic [IW-1:0] in_idx = '0;
  logic [KW-1:0] in_key_a = '0;
  logic [KW-1:0] in_key_b = '0;
  logic          done;
  logic [IW-1:0] rd_idx = '0;
  logic          rd_flag;

  int total = 0;
  int bad = 0;
  logic exp_flag [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  weak_tone_selector #(.NDC(NDC), .NH(NH), .KW(KW), .IW(IW)) u_weak_tone_selector (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .in_idx(in_idx), .in_key_a(in_key_a), .in_key_b(in_key_b),
    .done(done), .rd_idx(rd_idx), .rd_flag(rd_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 64; i++) exp_flag[i] = 1'b0;
  endtask

  // check the whole flag array, plus a few indices past NDC (R5)
  task automatic check_flags(input string tag);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      rd_idx = IW'(i);
      #1;
      chk(tag, int'(rd_flag), int'(exp_flag[i]));
    end
  endtask

  task automatic send(input logic [IW-1:0] idx, input logic [KW-1:0] a,
                      input logic [KW-1:0] b, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_idx = idx; in_key_a = a; in_key_b = b; in_last = last;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic start_pkt();
    @(negedge clk);
    pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clear_exp();
    repeat (3) @(negedge clk);
    // reset state
    chk("R7 reset done", int'(done), 0);
    chk("R8 reset ready", int'(in_ready), 1);
    rd_idx = 6'd15; #1;
    chk("R5 reset flag", int'(rd_flag), 0);
    rst_n = 1'b1;

    // packet 1: table walk, with eviction and a three-way tie at 650 (R1 R2 R3)
    start_pkt();
    for (int v = 0; v < NV; v++) begin
      logic [38:0] row;
      row = VEC[v];
      exp_flag[row[38:33]] = row[0];
      if (v < NV-1) begin
        send(row[38:33], row[32:17], row[16:1], 1'b0);
        chk("R8 ready during stream", int'(in_ready), 1);
      end else begin
        @(negedge clk);
        rd_idx = 6'd15;
        in_valid = 1'b1; in_idx = row[38:33]; in_key_a = row[32:17];
        in_key_b = row[16:1]; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        // R7: last taken, flags not yet written
        chk("R7 done early", int'(done), 0);
        chk("R7 flag early", int'(rd_flag), 0);
        @(negedge clk);
        chk("R7 done pulse", int'(done), 1);
        chk("R7 flag with done", int'(rd_flag), 1);
        @(negedge clk);
        chk("R7 done single", int'(done), 0);
      end
    end
    check_flags("R2 R3 packet one flags");

    // packet 2: only three carriers, at both ends of the array (R4 R6)
    start_pkt();
    clear_exp();
    rd_idx = 6'd15; #1;
    chk("R6 flags cleared", int'(rd_flag), 0);
    send(6'd0, 16'd9, 16'd90, 1'b0);
    send(6'd51, 16'd500, 16'd5, 1'b0);
    send(6'd26, 16'd7, 16'd7, 1'b1);
    exp_flag[0] = 1'b1; exp_flag[51] = 1'b1; exp_flag[26] = 1'b1;
    check_flags("R4 partial fill flags");

    // packet 3: bad index with smallest key, then six equal keys (R9 R3)
    start_pkt();
    clear_exp();
    send(6'd60, 16'd1, 16'd1, 1'b0);
    for (int c = 1; c <= 6; c++) begin
      send(IW'(c), 16'd1000, 16'd1000, c == 6);
      if (c <= 5) exp_flag[c] = 1'b1;
    end
    check_flags("R9 R3 equal keys and bad index");

    // packet 4: back-to-back samples, and pkt_start colliding with a sample (R8 R6)
    start_pkt();
    clear_exp();
    @(negedge clk);
    in_valid = 1'b1; in_idx = 6'd33; in_key_a = 16'd3; in_key_b = 16'd3; in_last = 1'b0;
    @(negedge clk);
    in_idx = 6'd34;
    @(negedge clk);
    in_idx = 6'd35; pkt_start = 1'b1;
    @(negedge clk);
    pkt_start = 1'b0; in_idx = 6'd36; in_last = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    chk("R7 done after burst", int'(done), 1);
    exp_flag[36] = 1'b1;
    check_flags("R6 R8 collision flags");

    // clear with no later packet: every flag returns to reduced search (R6)
    start_pkt();
    clear_exp();
    check_flags("R6 clear without done");
    chk("R7 no done after clear", int'(done), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule